// File: doc/BRIEF.md
# Encryption Window Matcher

This block decides, for every incoming bus address, whether the access lands inside one of eight programmable memory windows and whether that window requires encryption. Each window is bounded by a bottom and a top address held at 8-byte granularity. It covers the half-open span from the bottom up to, but not including, the top. Each window carries its own encrypt-enable bit. A single global valid bit must be set before any window can produce a hit.

Software programs the windows through a one-cycle write port. Each write names a window, a field and the requesting domain, which is 0 or 1. The bottom bound, the top bound and the control bit of a window each have a sticky lock that only reset clears. Each window also holds, for each of the two domains, a write-disable bit and a sticky lock that freezes that write-disable bit. Every write that is not applied raises a one-cycle error flag. The lookup result comes out one clock after the address is presented: a hit flag, the index of the matching window with the lowest number, and the encrypt flag.

Top module: `enc_window_match`

## Requirements
- R1: After reset, `hit`, `hit_idx`, `encrypt` and `cfg_err` are all 0, every window is empty and the global valid bit is clear.
- R2: While the global valid bit is clear, no address hits. That bit is written with `cfg_sel`=5 and `cfg_wdata[0]`, and this field ignores `cfg_reg` and `cfg_dom`.
- R3: Window i matches address A when bottom ≤ A[31:3] < top. The top granule itself is outside the window. Bounds are written with `cfg_sel`=0 (bottom) and `cfg_sel`=1 (top), and `cfg_wdata` carries the byte address.
- R4: A window whose top is less than or equal to its bottom never matches.
- R5: When several windows match, `hit_idx` reports the one with the lowest number.
- R6: `encrypt` equals the encrypt-enable bit of the reported window, and is 0 when there is no hit. That bit is written with `cfg_sel`=2 and `cfg_wdata[0]`.
- R7: `hit`, `hit_idx` and `encrypt` reflect the `lk_addr` value that was sampled at the preceding rising clock edge.
- R8: A bound write whose `cfg_wdata[2:0]` is nonzero is rejected. The bound keeps its value, and `cfg_err` is 1 in the cycle after the write.
- R9: A write with `cfg_sel`=3 sets sticky locks: `cfg_wdata[0]` locks the bottom, `[1]` locks the top and `[2]` locks the control bit. A later write to a locked field is dropped and raises `cfg_err`.
- R10: A write with `cfg_sel`=4 sets the write-disable bit of window `cfg_reg` for domain `cfg_dom` from `cfg_wdata[0]`. While that bit is set, writes from that domain with `cfg_sel` 0 to 3 to that window are dropped and raise `cfg_err`. The other domain is not affected.
- R11: The same `cfg_sel`=4 write sets the domain's sticky lock from `cfg_wdata[1]`. Once the lock is set, any later `cfg_sel`=4 write from that domain to that window is dropped and raises `cfg_err`.
- R12: A write with `cfg_sel` 6 or 7 changes nothing and raises `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dom | input | 1 | Domain issuing the write |
| cfg_reg | input | 3 | Target window index |
| cfg_sel | input | 3 | Field select |
| cfg_wdata | input | 32 | Write data |
| cfg_err | output | 1 | Previous write was not applied |
| lk_addr | input | 32 | Address to classify |
| hit | output | 1 | Address fell in an active window |
| hit_idx | output | 3 | Lowest-numbered matching window |
| encrypt | output | 1 | Matching window requires encryption |

## Verification
The hardest state to reach is a window whose configuration was frozen by one domain while the other domain still has write access. From the ports, the proof that a write was dropped is a lookup sweep whose results still follow the old bounds. The stimulus first builds overlapping, empty and inverted windows. It then locks fields and write-disables domains one at a time. After each attempted write, it sweeps addresses on 4-byte steps through every window edge and compares the results with an arithmetic model that is updated only for writes that should have been accepted.

// File: rtl/enc_window_match.sv
module enc_window_match #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int GRAN = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_dom,
  input  logic [$clog2(NREG)-1:0] cfg_reg,
  input  logic [2:0]              cfg_sel,
  input  logic [AW-1:0]           cfg_wdata,
  output logic                    cfg_err,
  input  logic [AW-1:0]           lk_addr,
  output logic                    hit,
  output logic [$clog2(NREG)-1:0] hit_idx,
  output logic                    encrypt
);
  localparam int IW = $clog2(NREG);
  localparam int GW = AW - GRAN;

  logic                     gvalid;
  logic [NREG-1:0][GW-1:0]  bot_q, top_q;
  logic [NREG-1:0]          en_q, lkb_q, lkt_q, lkc_q;
  logic [NREG-1:0][1:0]     wdis_q, dlk_q;

  logic          wr_blk, misal, accept;
  logic [GW-1:0] gaddr;
  logic [NREG-1:0] m;
  logic [IW-1:0] nidx;
  logic          unused_lo;

  assign wr_blk    = wdis_q[cfg_reg][cfg_dom];
  assign misal     = |cfg_wdata[GRAN-1:0];
  assign gaddr     = lk_addr[AW-1:GRAN];
  assign unused_lo = ^lk_addr[GRAN-1:0];

  always_comb begin
    case (cfg_sel)
      3'd0:    accept = !wr_blk && !lkb_q[cfg_reg] && !misal;
      3'd1:    accept = !wr_blk && !lkt_q[cfg_reg] && !misal;
      3'd2:    accept = !wr_blk && !lkc_q[cfg_reg];
      3'd3:    accept = !wr_blk;
      3'd4:    accept = !dlk_q[cfg_reg][cfg_dom];
      3'd5:    accept = 1'b1;
      default: accept = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gvalid  <= 1'b0;
      bot_q   <= '0;
      top_q   <= '0;
      en_q    <= '0;
      lkb_q   <= '0;
      lkt_q   <= '0;
      lkc_q   <= '0;
      wdis_q  <= '0;
      dlk_q   <= '0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= cfg_we && !accept;
      if (cfg_we && accept) begin
        case (cfg_sel)
          3'd0: bot_q[cfg_reg] <= cfg_wdata[AW-1:GRAN];
          3'd1: top_q[cfg_reg] <= cfg_wdata[AW-1:GRAN];
          3'd2: en_q[cfg_reg]  <= cfg_wdata[0];
          3'd3: begin
            lkb_q[cfg_reg] <= lkb_q[cfg_reg] | cfg_wdata[0];
            lkt_q[cfg_reg] <= lkt_q[cfg_reg] | cfg_wdata[1];
            lkc_q[cfg_reg] <= lkc_q[cfg_reg] | cfg_wdata[2];
          end
          3'd4: begin
            wdis_q[cfg_reg][cfg_dom] <= cfg_wdata[0];
            dlk_q[cfg_reg][cfg_dom]  <= cfg_wdata[1];
          end
          3'd5: gvalid <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_win
    assign m[i] = gvalid && (top_q[i] > bot_q[i]) &&
                  (gaddr >= bot_q[i]) && (gaddr < top_q[i]);
  end

  always_comb begin
    nidx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (m[i]) nidx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit     <= 1'b0;
      hit_idx <= '0;
      encrypt <= 1'b0;
    end else begin
      hit     <= |m;
      hit_idx <= nidx;
      encrypt <= (|m) && en_q[nidx];
    end
  end
endmodule

// File: rtl/enc_window_match_chk.sv
module enc_window_match_chk #(
  parameter int NREG = 8,
  parameter int GW   = 29,
  parameter int GRAN = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   gvalid,
  input logic                   hit,
  input logic                   encrypt,
  input logic                   cfg_we,
  input logic [2:0]             cfg_sel,
  input logic [GRAN-1:0]        wlow,
  input logic                   cfg_err,
  input logic [NREG-1:0]        lkb,
  input logic [NREG-1:0]        lkc,
  input logic [NREG-1:0]        en,
  input logic [NREG-1:0][GW-1:0] bot,
  input logic [NREG-1:0][1:0]   wdis,
  input logic [NREG-1:0][1:0]   dlk
);
  // R2
  gvalid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gvalid |=> !hit);

  // R6
  enc_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> !encrypt);

  // R8
  misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel <= 3'd1 && |wlow) |=> cfg_err);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    // R9
    bot_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lkb[i] |=> $stable(bot[i]));
    // R9
    ctl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lkc[i] |=> $stable(en[i]));
    for (genvar d = 0; d < 2; d++) begin : g_dom
      // R11
      dom_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlk[i][d] |=> $stable(wdis[i][d]));
    end
  end
endmodule

bind enc_window_match enc_window_match_chk #(.NREG(NREG), .GW(GW), .GRAN(GRAN)) chk (
  .clk(clk), .rst_n(rst_n), .gvalid(gvalid), .hit(hit), .encrypt(encrypt),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .wlow(cfg_wdata[GRAN-1:0]), .cfg_err(cfg_err),
  .lkb(lkb_q), .lkc(lkc_q), .en(en_q), .bot(bot_q), .wdis(wdis_q), .dlk(dlk_q)
);

// File: tb/enc_window_match_test.sv
module enc_window_match_test;
  localparam int CLK_PER = 10;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, cfg_dom = 0;
  logic [2:0]  cfg_reg = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, lk_addr = 0;
  logic        cfg_err, hit, encrypt;
  logic [2:0]  hit_idx;

  int n_chk = 0, n_bad = 0;
  int mb[8], mt[8];
  bit men[8];
  bit mgv = 0;

  always #(CLK_PER/2) clk = ~clk;

  enc_window_match uut (.*);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit d, input int r, input int s, input int v, input bit exp_err, input string req);
    @(negedge clk);
    cfg_we = 1; cfg_dom = d; cfg_reg = 3'(r); cfg_sel = 3'(s); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    chk(cfg_err == exp_err, req, "cfg_err", int'(cfg_err), int'(exp_err));
  endtask

  task automatic look(input int a, output bit h, output int ix, output bit e);
    @(negedge clk);
    lk_addr = a;
    @(negedge clk);
    h = hit; ix = int'(hit_idx); e = encrypt;
  endtask

  function automatic int model(int a);
    int g = a >>> 3;
    if (!mgv) return -1;
    for (int i = 0; i < 8; i++)
      if (mt[i] > mb[i] && g >= mb[i] && g < mt[i]) return i;
    return -1;
  endfunction

  task automatic sweep(string req);
    bit h, e; int ix, x;
    for (int a = 0; a < 400; a += 4) begin
      look(a, h, ix, e);
      x = model(a);
      chk(h == (x >= 0), req, $sformatf("hit @%0d", a), int'(h), int'(x >= 0));
      if (x >= 0) begin
        chk(ix == x, req, $sformatf("idx @%0d", a), ix, x);
        chk(e == men[x], req, $sformatf("enc @%0d", a), int'(e), int'(men[x]));
      end else
        chk(e == 0, req, $sformatf("enc @%0d", a), int'(e), 0);
    end
  endtask

  initial begin
    #(CLK_PER * 200000);
    chk(0, "WD", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mb[i] = 0; mt[i] = 0; men[i] = 0; end
    #(CLK_PER * 3);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    // R1
    chk(hit == 0 && hit_idx == 0 && encrypt == 0, "R1", "outputs", int'(hit), 0);
    chk(cfg_err == 0, "R1", "cfg_err", int'(cfg_err), 0);

    // overlapping windows, one empty (R4), one inverted (R4)
    for (int i = 0; i < 6; i++) begin
      mb[i] = 4 * i; mt[i] = 4 * i + 10; men[i] = i[0];
      wr(0, i, 0, mb[i] * 8, 0, "R3");
      wr(0, i, 1, mt[i] * 8, 0, "R3");
      wr(0, i, 2, int'(men[i]), 0, "R6");
    end
    mb[6] = 40; mt[6] = 35; men[6] = 1;
    wr(0, 6, 0, 320, 0, "R4"); wr(0, 6, 1, 280, 0, "R4"); wr(0, 6, 2, 1, 0, "R4");
    mb[7] = 42; mt[7] = 42; men[7] = 1;
    wr(1, 7, 0, 336, 0, "R4"); wr(1, 7, 1, 336, 0, "R4"); wr(1, 7, 2, 1, 0, "R4");

    sweep("R2");
    mgv = 1;
    wr(1, 3, 5, 1, 0, "R2");
    sweep("R3 R4 R5 R6");

    // R8
    wr(0, 0, 0, 32'h13, 1, "R8");
    wr(0, 0, 1, 32'h55, 1, "R8");
    sweep("R8");

    // R9
    wr(0, 1, 3, 1, 0, "R9");
    wr(0, 1, 0, 0, 1, "R9");
    wr(0, 2, 3, 2, 0, "R9");
    wr(1, 2, 1, 400, 1, "R9");
    wr(0, 3, 3, 4, 0, "R9");
    wr(0, 3, 2, 0, 1, "R9");
    wr(0, 3, 0, 64, 0, "R9"); mb[3] = 8;
    sweep("R9");

    // R10
    wr(1, 4, 4, 1, 0, "R10");
    wr(1, 4, 0, 0, 1, "R10");
    wr(1, 4, 2, 0, 1, "R10");
    sweep("R10");
    wr(0, 4, 0, 80, 0, "R10"); mb[4] = 10;
    sweep("R10");

    // R11
    wr(1, 4, 4, 3, 0, "R11");
    wr(1, 4, 4, 0, 1, "R11");
    wr(1, 4, 1, 400, 1, "R11");
    wr(0, 4, 4, 0, 0, "R11");
    wr(0, 4, 1, 200, 0, "R11"); mt[4] = 25;
    sweep("R11");

    // R12
    wr(0, 5, 6, 0, 1, "R12");
    wr(0, 5, 7, 0, 1, "R12");
    sweep("R12");

    // R7: output holds until the next rising edge, then updates
    begin
      bit h, e; int ix;
      look(0, h, ix, e);
      @(negedge clk);
      lk_addr = 396;
      #1;
      chk(hit == 1 && hit_idx == 0, "R7", "before edge", int'(hit), 1);
      @(negedge clk);
      chk(hit == 0, "R7", "after edge", int'(hit), 0);
    end

    // R2 again: clearing the global valid bit
    mgv = 0;
    wr(0, 0, 5, 0, 0, "R2");
    sweep("R2");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule